// File: doc/BRIEF.md
# Masked Interrupt Cause Controller

This block gathers single-cycle event pulses from the units of a network controller and turns them into one level-sensitive interrupt line. Each event sets a sticky bit in a cause register. Software sees and manages that register through four word-wide registers on a simple strobe bus: the cause register itself, a cause-set register, a mask-set register and a mask-clear register.

Reading the cause register returns its value and clears it in the same access. Writing it clears the bits written as one. The top bit of the cause word is a summary flag that reads as one whenever any other cause bit is set. The interrupt line is high whenever the mask and the cause word (summary flag included) share a set bit. It is computed from the stored state, so it follows every register access or event on the next clock edge.

Top module: `irq_cause_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the cause bits and the mask, so `irq` is low and both the cause and mask registers read 0 after reset.
- R2: An event pulse on `evt[i]` sets cause bit i (event i maps to bit i) at the next clock edge; bits set by earlier events stay set until cleared.
- R3: A write to the cause-set register (`sel_cset`) ORs `wdata[30:0]` into the cause bits; `wdata[31]` of that write stores nothing.
- R4: A write to the cause register (`sel_cause`) clears every cause bit whose `wdata` bit is 1 and leaves the others unchanged.
- R5: A read of the cause register returns the current cause word in the same cycle as the read strobe, and the cause bits are all zero after that clock edge.
- R6: An event that arrives in the same cycle as a clearing read or a clearing write of the cause register is kept: its bit is set after that edge.
- R7: Bit 31 of the cause word reads 1 exactly when at least one of bits 30:0 is set, and returns to 0 once they are all cleared.
- R8: A write to the mask-set register ORs `wdata` into the 32-bit mask; a write to the mask-clear register clears the mask bits written as 1; if both act in one cycle, clearing wins.
- R9: A read with `sel_mset` returns the mask; reads with `sel_cset` or `sel_mclr` return 0; `rdata` is 0 whenever `rd_en` is low.
- R10: `irq` is high exactly when the mask ANDed with the 32-bit cause word is nonzero, so mask bit 31 alone raises `irq` for any cause; it reflects each update from the following clock edge on.
- R11: Mask accesses leave the cause bits unchanged and cause accesses leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| sel_cause | input | 1 | Selects the cause register |
| sel_cset | input | 1 | Selects the cause-set register |
| sel_mset | input | 1 | Selects the mask-set register (reads return the mask) |
| sel_mclr | input | 1 | Selects the mask-clear register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| evt | input | EVT_W | Event pulses, one per low cause bit |
| irq | output | 1 | Level interrupt output |

## Verification
Read data is combinational, so each read result is sampled in the strobe cycle itself, shortly after the inputs are driven on the falling edge. Register writes, clearing reads and event pulses take effect at the next rising edge. Their effect on the cause and mask is therefore checked with a read in a later cycle. `irq` is read off the stored state, so it is sampled on the falling edge after the updating edge. The bench also confirms that `irq` still shows its old value in the stimulus cycle. The race cases drive the event and the clearing access in one cycle and read back on the next.

// File: rtl/icc_pkg.sv
package icc_pkg;

   // Decoded single-cycle actions on the cause and mask state
   typedef struct packed {
      logic cause_rd;   // read of cause register (clears it)
      logic cause_clr;  // write-one-to-clear on cause register
      logic cause_set;  // OR into cause bits
      logic mask_set;   // OR into mask
      logic mask_clr;   // clear bits of mask
   } icc_strobe_t;

endpackage

// File: rtl/icc_bus_decode.sv
module icc_bus_decode
   import icc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              sel_cause,
   input  logic              sel_cset,
   input  logic              sel_mset,
   input  logic              sel_mclr,
   input  logic [DATA_W-1:0] cause_word,
   input  logic [DATA_W-1:0] mask_word,
   output icc_strobe_t       stb,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      stb.cause_rd  = rd_en & sel_cause;
      stb.cause_clr = wr_en & sel_cause;
      stb.cause_set = wr_en & sel_cset;
      stb.mask_set  = wr_en & sel_mset;
      stb.mask_clr  = wr_en & sel_mclr;
   end

   // Set/clear-only registers return zero; mask readable through its set address
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (sel_cause)     rdata = cause_word;
         else if (sel_mset) rdata = mask_word;
      end
   end

endmodule

// File: rtl/icc_event_front.sv
module icc_event_front #(
   parameter int EVT_W     = 8,
   parameter int CAUSE_W   = 31,
   parameter bit EVENT_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [EVT_W-1:0]   evt,
   output logic [CAUSE_W-1:0] evt_vec
);

   logic [EVT_W-1:0] evt_s;

   generate
      if (EVENT_REG) begin : g_staged
         always_ff @(posedge clk) begin
            if (rst) evt_s <= '0;
            else     evt_s <= evt;
         end
      end else begin : g_direct
         assign evt_s = evt;
      end
   endgenerate

   generate
      for (genvar i = 0; i < CAUSE_W; i++) begin : g_map
         if (i < EVT_W) begin : g_src
            assign evt_vec[i] = evt_s[i];
         end else begin : g_zero
            assign evt_vec[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/icc_cause_store.sv
module icc_cause_store
   import icc_pkg::*;
#(
   parameter int CAUSE_W = 31
) (
   input  logic               clk,
   input  logic               rst,
   input  icc_strobe_t        stb,
   input  logic [CAUSE_W-1:0] wbits,
   input  logic [CAUSE_W-1:0] evt_vec,
   output logic [CAUSE_W-1:0] bits,
   output logic               summary
);

   logic [CAUSE_W-1:0] nxt;

   // Order: read-clear, then write-one-clear, then set, then events win
   always_comb begin
      nxt = bits;
      if (stb.cause_rd)  nxt = '0;
      if (stb.cause_clr) nxt = nxt & ~wbits;
      if (stb.cause_set) nxt = nxt | wbits;
      nxt = nxt | evt_vec;
   end

   always_ff @(posedge clk) begin
      if (rst) bits <= '0;
      else     bits <= nxt;
   end

   assign summary = |bits;

   p_set_or_r3: assert property (@(posedge clk) disable iff (rst)
      stb.cause_set |=> ((bits & $past(wbits)) == $past(wbits)));

   p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
      (stb.cause_clr && !stb.cause_set) |=>
         ((bits & $past(wbits) & ~$past(evt_vec)) == '0));

   p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
      (stb.cause_rd && !stb.cause_set && evt_vec == '0) |=> (bits == '0));

   p_event_kept_r6: assert property (@(posedge clk) disable iff (rst)
      (evt_vec != '0) |=> ((bits & $past(evt_vec)) == $past(evt_vec)));

   p_cause_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!stb.cause_rd && !stb.cause_clr && !stb.cause_set && evt_vec == '0)
         |=> $stable(bits));

endmodule

// File: rtl/icc_mask_store.sv
module icc_mask_store
   import icc_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  icc_strobe_t       stb,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] mask
);

   logic [DATA_W-1:0] set_v;
   logic [DATA_W-1:0] clr_v;

   assign set_v = stb.mask_set ? wdata : '0;
   assign clr_v = stb.mask_clr ? wdata : '0;

   always_ff @(posedge clk) begin
      if (rst) mask <= '0;
      else     mask <= (mask | set_v) & ~clr_v;
   end

   p_mask_set_r8: assert property (@(posedge clk) disable iff (rst)
      (stb.mask_set && !stb.mask_clr) |=> ((mask & $past(wdata)) == $past(wdata)));

   p_mask_clr_r8: assert property (@(posedge clk) disable iff (rst)
      stb.mask_clr |=> ((mask & $past(wdata)) == '0));

   p_mask_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (!stb.mask_set && !stb.mask_clr) |=> $stable(mask));

endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
   import icc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int EVT_W     = 8,
   parameter bit EVENT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              sel_cause,
   input  logic              sel_cset,
   input  logic              sel_mset,
   input  logic              sel_mclr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [EVT_W-1:0]  evt,
   output logic              irq
);

   localparam int CAUSE_W = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must leave room for the summary bit");
      end
      if (EVT_W < 1 || EVT_W > CAUSE_W) begin : g_bad_evt
         $error("EVT_W must be between 1 and DATA_W-1");
      end
   endgenerate

   icc_strobe_t        stb;
   logic [CAUSE_W-1:0] evt_vec;
   logic [CAUSE_W-1:0] cause_bits;
   logic               summary;
   logic [DATA_W-1:0]  cause_word;
   logic [DATA_W-1:0]  mask_word;

   icc_bus_decode #(.DATA_W(DATA_W)) u_dec (
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .sel_cause  (sel_cause),
      .sel_cset   (sel_cset),
      .sel_mset   (sel_mset),
      .sel_mclr   (sel_mclr),
      .cause_word (cause_word),
      .mask_word  (mask_word),
      .stb        (stb),
      .rdata      (rdata)
   );

   icc_event_front #(.EVT_W(EVT_W), .CAUSE_W(CAUSE_W), .EVENT_REG(EVENT_REG)) u_evt (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt),
      .evt_vec (evt_vec)
   );

   icc_cause_store #(.CAUSE_W(CAUSE_W)) u_cause (
      .clk     (clk),
      .rst     (rst),
      .stb     (stb),
      .wbits   (wdata[CAUSE_W-1:0]),
      .evt_vec (evt_vec),
      .bits    (cause_bits),
      .summary (summary)
   );

   icc_mask_store #(.DATA_W(DATA_W)) u_mask (
      .clk   (clk),
      .rst   (rst),
      .stb   (stb),
      .wdata (wdata),
      .mask  (mask_word)
   );

   assign cause_word = {summary, cause_bits};
   assign irq        = |(mask_word & cause_word);

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!irq && rdata == '0 || rd_en));

   p_summary_r7: assert property (@(posedge clk) disable iff (rst)
      (rd_en && sel_cause && rdata[CAUSE_W-1:0] != '0) |-> rdata[DATA_W-1]);

   p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (rst)
      (mask_word == '0) |-> !irq);

   p_irq_needs_cause_r10: assert property (@(posedge clk) disable iff (rst)
      (cause_bits == '0) |-> !irq);

endmodule

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int EW = 8;

   localparam logic [3:0] S_CAUSE = 4'b0001;
   localparam logic [3:0] S_CSET  = 4'b0010;
   localparam logic [3:0] S_MSET  = 4'b0100;
   localparam logic [3:0] S_MCLR  = 4'b1000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic          sel_cause = 1'b0, sel_cset = 1'b0, sel_mset = 1'b0, sel_mclr = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic [EW-1:0] evt = '0;
   logic          irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_cause_ctrl #(.DATA_W(DW), .EVT_W(EW)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .sel_cause(sel_cause), .sel_cset(sel_cset), .sel_mset(sel_mset), .sel_mclr(sel_mclr),
      .wdata(wdata), .rdata(rdata), .evt(evt), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   // One bus cycle: drive on falling edge, sample read data in the same cycle,
   // release after the rising edge.
   task automatic op(input logic wr, input logic rd, input logic [3:0] sel,
                     input logic [DW-1:0] d, input logic [EW-1:0] ev,
                     output logic [DW-1:0] rv);
      @(negedge clk);
      wr_en = wr; rd_en = rd;
      {sel_mclr, sel_mset, sel_cset, sel_cause} = sel;
      wdata = d; evt = ev;
      #1 rv = rdata;
      @(posedge clk);
      #1;
      wr_en = 1'b0; rd_en = 1'b0;
      {sel_mclr, sel_mset, sel_cset, sel_cause} = 4'b0;
      wdata = '0; evt = '0;
   endtask

   task automatic wr(input logic [3:0] sel, input logic [DW-1:0] d);
      logic [DW-1:0] rv;
      op(1'b1, 1'b0, sel, d, '0, rv);
   endtask

   task automatic rd(input logic [3:0] sel, output logic [DW-1:0] rv);
      op(1'b0, 1'b1, sel, '0, '0, rv);
   endtask

   task automatic pulse(input logic [EW-1:0] ev);
      logic [DW-1:0] rv;
      op(1'b0, 1'b0, 4'b0, '0, ev, rv);
   endtask

   task automatic check_irq(input string req, input logic exp);
      @(negedge clk);
      #1 check(req, "irq", {31'b0, irq}, {31'b0, exp});
   endtask

   task automatic t_reset;
      logic [DW-1:0] v;
      rd(S_CAUSE, v); check("R1", "cause after reset", v, 32'h0);
      rd(S_MSET, v);  check("R1", "mask after reset", v, 32'h0);
      check_irq("R1", 1'b0);
   endtask

   task automatic t_events;
      logic [DW-1:0] v;
      pulse(8'h05);
      rd(S_CAUSE, v); check("R2", "two events one cycle", v, 32'h8000_0005);
      pulse(8'h01);
      pulse(8'h80);
      rd(S_CAUSE, v); check("R2", "events accumulate", v, 32'h8000_0081);
   endtask

   task automatic t_cause_set;
      logic [DW-1:0] v;
      wr(S_CSET, 32'h8000_1200);
      wr(S_CSET, 32'h0000_0010);
      rd(S_CAUSE, v); check("R3", "cause-set ORs", v, 32'h8000_1210);
      wr(S_CSET, 32'h8000_0000);
      rd(S_CAUSE, v); check("R3", "write bit31 stores nothing", v, 32'h0);
   endtask

   task automatic t_read_clear;
      logic [DW-1:0] v;
      wr(S_CSET, 32'h0000_0300);
      rd(S_CAUSE, v); check("R5", "read returns value", v, 32'h8000_0300);
      rd(S_CAUSE, v); check("R5", "cleared after read", v, 32'h0);
   endtask

   task automatic t_w1c;
      logic [DW-1:0] v;
      wr(S_CSET, 32'h0000_F00F);
      wr(S_CAUSE, 32'h0000_0F0F);
      rd(S_CAUSE, v); check("R4", "write-one-clear keeps others", v, 32'h8000_F000);
      wr(S_CSET, 32'h0000_F000);
      wr(S_CAUSE, 32'h0000_F000);
      rd(S_CAUSE, v); check("R7", "summary drops when empty", v, 32'h0);
   endtask

   task automatic t_race;
      logic [DW-1:0] v;
      wr(S_CSET, 32'h0000_0004);
      op(1'b0, 1'b1, S_CAUSE, '0, 8'h02, v);
      check("R6", "read value during race", v, 32'h8000_0004);
      rd(S_CAUSE, v); check("R6", "event kept over clearing read", v, 32'h8000_0002);
      op(1'b1, 1'b0, S_CAUSE, 32'h0000_0040, 8'h40, v);
      rd(S_CAUSE, v); check("R6", "event kept over clearing write", v, 32'h8000_0040);
   endtask

   task automatic t_mask;
      logic [DW-1:0] v;
      wr(S_MSET, 32'h0000_00F0);
      wr(S_MSET, 32'h0000_0003);
      rd(S_MSET, v); check("R8", "mask set ORs", v, 32'h0000_00F3);
      wr(S_MCLR, 32'h0000_0030);
      rd(S_MSET, v); check("R8", "mask clear", v, 32'h0000_00C3);
      op(1'b1, 1'b0, S_MSET | S_MCLR, 32'h0000_0100, '0, v);
      rd(S_MSET, v); check("R8", "clear wins over set", v, 32'h0000_00C3);
      rd(S_CSET, v); check("R9", "cause-set reads zero", v, 32'h0);
      rd(S_MCLR, v); check("R9", "mask-clear reads zero", v, 32'h0);
      op(1'b0, 1'b0, S_MSET, '0, '0, v); check("R9", "no read strobe", v, 32'h0);
   endtask

   task automatic t_irq;
      logic [DW-1:0] v;
      // mask is 0x000000C3 here
      check_irq("R10", 1'b0);
      pulse(8'h04);
      check_irq("R10", 1'b0);
      @(negedge clk);
      evt = 8'h01;
      #1 check("R10", "irq not yet in stimulus cycle", {31'b0, irq}, 32'h0);
      @(posedge clk); #1 evt = '0;
      check_irq("R10", 1'b1);
      rd(S_CAUSE, v); check("R2", "unmasked and masked events", v, 32'h8000_0005);
      check_irq("R10", 1'b0);
      wr(S_MCLR, 32'hFFFF_FFFF);
      wr(S_MSET, 32'h8000_0000);
      wr(S_CSET, 32'h0010_0000);
      check_irq("R10", 1'b1);
      wr(S_CAUSE, 32'h0010_0000);
      check_irq("R10", 1'b0);
   endtask

   task automatic t_isolation;
      logic [DW-1:0] v;
      wr(S_CSET, 32'h0000_0020);
      wr(S_MSET, 32'h0000_0F00);
      wr(S_MCLR, 32'h0000_0100);
      rd(S_CAUSE, v); check("R11", "mask access leaves cause", v, 32'h8000_0020);
      rd(S_MSET, v);  check("R11", "cause access leaves mask", v, 32'h8000_0E00);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      t_reset();
      t_events();
      t_cause_set();
      t_read_clear();
      t_w1c();
      t_race();
      t_mask();
      t_irq();
      t_isolation();
      repeat (2) @(posedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule